// File: doc/BRIEF.md
# Operand Forwarding Selection Unit

This block picks the bypass source for every operand of an in-order five-stage pipeline. Each of the two execute-stage ALU operands can come from three places: the register-file read captured in decode, the result waiting in the execute/memory pipeline register, or the result waiting in the memory/writeback pipeline register. Each of the two decode-stage branch-compare operands can come from two places: the register-file read or the execute/memory result. Because of the branch-compare path, a branch can be resolved early, in decode.

The selection is made by comparing the source register numbers of the consuming instruction with the destination numbers of the older instructions still in flight. A match counts only when the producer really writes a register. The register file writes early in the cycle and reads late, so a producer three slots ahead needs no bypass. The block also contains the operand multiplexers. Each select is output as a 2-bit code, and the multiplexed values are output next to it. Stall generation for load-use cases is handled outside this block.

Top module: `operand_bypass_unit`

## Requirements
- R1: When no in-flight producer matches, every select is 00 and each operand equals its own register-file value.
- R2: An ALU operand whose source register equals the execute/memory destination, with that write enable set and that destination nonzero, gets select 10 and the execute/memory ALU result.
- R3: An ALU operand that matches only the memory/writeback producer (write enable set, destination nonzero) gets select 01 and the memory/writeback result.
- R4: When both producers match the same source, the execute/memory producer, being the younger one, wins with select 10.
- R5: Register 0 is never forwarded. A destination of 0 produces no match even with its write enable set.
- R6: A producer whose write enable is clear produces no match, even when its destination equals the source.
- R7: The memory/writeback value that is forwarded is the load data when the load flag is 1, and the ALU result when it is 0.
- R8: A branch operand gets select 10 and the execute/memory result on an execute/memory match. Otherwise it gets select 00 and its decode register-file value, including when only memory/writeback matches.
- R9: The two operands of each stage are decided independently. One may forward while the other does not, and they may forward from different stages.
- R10: The code 11 is never produced. Selects and operands are combinational and follow their inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exSrcA | input | REG_AW | Execute-stage source register of ALU operand A |
| exSrcB | input | REG_AW | Execute-stage source register of ALU operand B |
| exRfA | input | DATA_W | Register-file value captured for operand A |
| exRfB | input | DATA_W | Register-file value captured for operand B |
| idSrcA | input | REG_AW | Decode-stage source register of branch operand A |
| idSrcB | input | REG_AW | Decode-stage source register of branch operand B |
| idRfA | input | DATA_W | Register-file read for branch operand A |
| idRfB | input | DATA_W | Register-file read for branch operand B |
| exMemWrEn | input | 1 | Execute/memory producer writes a register |
| exMemDest | input | REG_AW | Execute/memory destination register |
| exMemAluRes | input | DATA_W | Execute/memory ALU result |
| memWbWrEn | input | 1 | Memory/writeback producer writes a register |
| memWbDest | input | REG_AW | Memory/writeback destination register |
| memWbIsLoad | input | 1 | Memory/writeback producer is a load |
| memWbAluRes | input | DATA_W | Memory/writeback ALU result |
| memWbLoadData | input | DATA_W | Memory/writeback load data |
| aluSelA | output | 2 | Select code for ALU operand A |
| aluSelB | output | 2 | Select code for ALU operand B |
| aluOpA | output | DATA_W | Chosen ALU operand A |
| aluOpB | output | DATA_W | Chosen ALU operand B |
| brSelA | output | 2 | Select code for branch operand A |
| brSelB | output | 2 | Select code for branch operand B |
| brOpA | output | DATA_W | Chosen branch operand A |
| brOpB | output | DATA_W | Chosen branch operand B |

## Verification
The hardest situation to reach is a double match where the priority rule decides. The two producers target the same register, both enables are set, and the destination is nonzero. Meanwhile the memory/writeback slot holds a load whose data differs from its ALU result, so a wrong stage choice or a wrong memory/writeback value shows up as a different operand word. The stimulus table drives this situation directly through the producer ports. Each data source carries a distinct constant, so every select error and every value error can be seen at the outputs. Neighbouring entries then switch off one enable at a time, or move the destination to register 0, to show that each qualifier on its own removes the match.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  localparam int NUM_OPS = 2;

  typedef enum logic [1:0] {
    SEL_RF    = 2'b00,
    SEL_MEMWB = 2'b01,
    SEL_EXMEM = 2'b10
  } fwdSel_e;

  typedef struct packed {
    fwdSel_e [NUM_OPS-1:0] aluSel;
    fwdSel_e [NUM_OPS-1:0] brSel;
  } fwdStrobes_t;

endpackage

// File: rtl/fwd_select_ctrl.sv
module fwd_select_ctrl
  import fwd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [NUM_OPS-1:0][REG_AW-1:0] exSrc,
  input  logic [NUM_OPS-1:0][REG_AW-1:0] idSrc,
  input  logic                           exMemWrEn,
  input  logic [REG_AW-1:0]              exMemDest,
  input  logic                           memWbWrEn,
  input  logic [REG_AW-1:0]              memWbDest,
  output fwdStrobes_t                    strobes
);

  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  // A producer is live only if it writes and does not target the zero register.
  logic exMemLive;
  logic memWbLive;
  assign exMemLive = exMemWrEn && (exMemDest != ZERO_REG);
  assign memWbLive = memWbWrEn && (memWbDest != ZERO_REG);

  fwdSel_e [NUM_OPS-1:0] aluSelW;
  fwdSel_e [NUM_OPS-1:0] brSelW;

  for (genvar op = 0; op < NUM_OPS; op++) begin : g_op
    logic exHit;
    logic wbHit;
    logic idHit;

    assign exHit = exMemLive && (exMemDest == exSrc[op]);
    assign wbHit = memWbLive && (memWbDest == exSrc[op]);
    assign idHit = exMemLive && (exMemDest == idSrc[op]);

    // Younger producer (execute/memory) has priority.
    always_comb begin
      if (exHit)      aluSelW[op] = SEL_EXMEM;
      else if (wbHit) aluSelW[op] = SEL_MEMWB;
      else            aluSelW[op] = SEL_RF;
    end

    // Writeback match needs no bypass: the register file writes first.
    assign brSelW[op] = idHit ? SEL_EXMEM : SEL_RF;

    always_comb begin
      assert_no_bad_code_R10: assert (aluSelW[op] != 2'b11 && brSelW[op] != 2'b11)
        else $error("illegal select code on operand %0d", op);
      if (exSrc[op] == ZERO_REG) begin
        assert_zero_alu_R5: assert (aluSelW[op] == SEL_RF)
          else $error("register 0 forwarded to ALU operand %0d", op);
      end
      if (idSrc[op] == ZERO_REG) begin
        assert_zero_br_R5: assert (brSelW[op] == SEL_RF)
          else $error("register 0 forwarded to branch operand %0d", op);
      end
      if (!exMemWrEn && !memWbWrEn) begin
        assert_no_writer_R6: assert (aluSelW[op] == SEL_RF && brSelW[op] == SEL_RF)
          else $error("forward with both write enables clear, operand %0d", op);
      end
      if (exMemWrEn && memWbWrEn && exMemDest == memWbDest && exMemDest == exSrc[op]
          && exSrc[op] != ZERO_REG) begin
        assert_younger_wins_R4: assert (aluSelW[op] == SEL_EXMEM)
          else $error("double match did not pick execute/memory, operand %0d", op);
      end
      assert_br_no_wb_R8: assert (brSelW[op] != SEL_MEMWB)
        else $error("branch operand %0d selected writeback path", op);
    end
  end : g_op

  assign strobes.aluSel = aluSelW;
  assign strobes.brSel  = brSelW;

endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwdStrobes_t                    strobes,
  input  logic [NUM_OPS-1:0][DATA_W-1:0] exRf,
  input  logic [NUM_OPS-1:0][DATA_W-1:0] idRf,
  input  logic [DATA_W-1:0]              exMemAluRes,
  input  logic                           memWbIsLoad,
  input  logic [DATA_W-1:0]              memWbAluRes,
  input  logic [DATA_W-1:0]              memWbLoadData,
  output logic [NUM_OPS-1:0][DATA_W-1:0] aluOp,
  output logic [NUM_OPS-1:0][DATA_W-1:0] brOp
);

  // The value a writeback-stage producer is about to commit.
  logic [DATA_W-1:0] memWbResult;
  assign memWbResult = memWbIsLoad ? memWbLoadData : memWbAluRes;

  for (genvar op = 0; op < NUM_OPS; op++) begin : g_mux
    always_comb begin
      unique case (strobes.aluSel[op])
        SEL_EXMEM: aluOp[op] = exMemAluRes;
        SEL_MEMWB: aluOp[op] = memWbResult;
        default:   aluOp[op] = exRf[op];
      endcase
    end

    always_comb begin
      if (strobes.brSel[op] == SEL_EXMEM) brOp[op] = exMemAluRes;
      else                                brOp[op] = idRf[op];
    end
  end : g_mux

endmodule

// File: rtl/operand_bypass_unit.sv
module operand_bypass_unit
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] exSrcA,
  input  logic [REG_AW-1:0] exSrcB,
  input  logic [DATA_W-1:0] exRfA,
  input  logic [DATA_W-1:0] exRfB,
  input  logic [REG_AW-1:0] idSrcA,
  input  logic [REG_AW-1:0] idSrcB,
  input  logic [DATA_W-1:0] idRfA,
  input  logic [DATA_W-1:0] idRfB,
  input  logic              exMemWrEn,
  input  logic [REG_AW-1:0] exMemDest,
  input  logic [DATA_W-1:0] exMemAluRes,
  input  logic              memWbWrEn,
  input  logic [REG_AW-1:0] memWbDest,
  input  logic              memWbIsLoad,
  input  logic [DATA_W-1:0] memWbAluRes,
  input  logic [DATA_W-1:0] memWbLoadData,
  output logic [1:0]        aluSelA,
  output logic [1:0]        aluSelB,
  output logic [DATA_W-1:0] aluOpA,
  output logic [DATA_W-1:0] aluOpB,
  output logic [1:0]        brSelA,
  output logic [1:0]        brSelB,
  output logic [DATA_W-1:0] brOpA,
  output logic [DATA_W-1:0] brOpB
);

  fwdStrobes_t strobes;
  logic [NUM_OPS-1:0][DATA_W-1:0] aluOpW;
  logic [NUM_OPS-1:0][DATA_W-1:0] brOpW;

  fwd_select_ctrl #(.REG_AW(REG_AW)) u_ctrl (
    .exSrc     ({exSrcB, exSrcA}),
    .idSrc     ({idSrcB, idSrcA}),
    .exMemWrEn (exMemWrEn),
    .exMemDest (exMemDest),
    .memWbWrEn (memWbWrEn),
    .memWbDest (memWbDest),
    .strobes   (strobes)
  );

  fwd_operand_mux #(.DATA_W(DATA_W)) u_mux (
    .strobes       (strobes),
    .exRf          ({exRfB, exRfA}),
    .idRf          ({idRfB, idRfA}),
    .exMemAluRes   (exMemAluRes),
    .memWbIsLoad   (memWbIsLoad),
    .memWbAluRes   (memWbAluRes),
    .memWbLoadData (memWbLoadData),
    .aluOp         (aluOpW),
    .brOp          (brOpW)
  );

  assign aluSelA = strobes.aluSel[0];
  assign aluSelB = strobes.aluSel[1];
  assign brSelA  = strobes.brSel[0];
  assign brSelB  = strobes.brSel[1];
  assign aluOpA  = aluOpW[0];
  assign aluOpB  = aluOpW[1];
  assign brOpA   = brOpW[0];
  assign brOpB   = brOpW[1];

endmodule

// File: tb/tb_operand_bypass_unit.sv
module tb_operand_bypass_unit;

  localparam logic [31:0] RF_A   = 32'h1111_0001;
  localparam logic [31:0] RF_B   = 32'h2222_0002;
  localparam logic [31:0] ID_A   = 32'h3333_0003;
  localparam logic [31:0] ID_B   = 32'h4444_0004;
  localparam logic [31:0] EM_RES = 32'hE0E0_0010;
  localparam logic [31:0] WB_RES = 32'hB0B0_0020;
  localparam logic [31:0] LD_DAT = 32'hDADA_0030;

  typedef struct packed {
    logic [4:0] exA;
    logic [4:0] exB;
    logic [4:0] idA;
    logic [4:0] idB;
    logic [4:0] emDest;
    logic       emWe;
    logic [4:0] wbDest;
    logic       wbWe;
    logic       wbLd;
    logic [1:0] expA;
    logic [1:0] expB;
    logic       expBrA;
    logic       expBrB;
    logic [3:0] tag;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{5'd3,  5'd4,  5'd5,  5'd6,  5'd7,  1'b1, 5'd8,  1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 4'd1},
    '{5'd7,  5'd4,  5'd9,  5'd6,  5'd7,  1'b1, 5'd8,  1'b1, 1'b0, 2'b10, 2'b00, 1'b0, 1'b0, 4'd2},
    '{5'd3,  5'd8,  5'd5,  5'd6,  5'd7,  1'b1, 5'd8,  1'b1, 1'b0, 2'b00, 2'b01, 1'b0, 1'b0, 4'd3},
    '{5'd9,  5'd9,  5'd9,  5'd9,  5'd9,  1'b1, 5'd9,  1'b1, 1'b1, 2'b10, 2'b10, 1'b1, 1'b1, 4'd4},
    '{5'd0,  5'd0,  5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 4'd5},
    '{5'd12, 5'd12, 5'd12, 5'd12, 5'd12, 1'b0, 5'd12, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 4'd6},
    '{5'd5,  5'd2,  5'd1,  5'd1,  5'd3,  1'b1, 5'd5,  1'b1, 1'b1, 2'b01, 2'b00, 1'b0, 1'b0, 4'd7},
    '{5'd5,  5'd5,  5'd5,  5'd5,  5'd3,  1'b1, 5'd5,  1'b1, 1'b0, 2'b01, 2'b01, 1'b0, 1'b0, 4'd8},
    '{5'd10, 5'd11, 5'd10, 5'd11, 5'd10, 1'b1, 5'd11, 1'b1, 1'b0, 2'b10, 2'b01, 1'b1, 1'b0, 4'd9},
    '{5'd31, 5'd31, 5'd31, 5'd31, 5'd31, 1'b1, 5'd31, 1'b0, 1'b0, 2'b10, 2'b10, 1'b1, 1'b1, 4'd4},
    '{5'd14, 5'd15, 5'd14, 5'd2,  5'd2,  1'b1, 5'd14, 1'b1, 1'b1, 2'b01, 2'b00, 1'b0, 1'b1, 4'd8},
    '{5'd0,  5'd6,  5'd0,  5'd6,  5'd0,  1'b1, 5'd6,  1'b1, 1'b0, 2'b00, 2'b01, 1'b0, 1'b0, 4'd5}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0]  exSrcA, exSrcB, idSrcA, idSrcB, exMemDest, memWbDest;
  logic [31:0] exRfA, exRfB, idRfA, idRfB, exMemAluRes, memWbAluRes, memWbLoadData;
  logic        exMemWrEn, memWbWrEn, memWbIsLoad;
  logic [1:0]  aluSelA, aluSelB, brSelA, brSelB;
  logic [31:0] aluOpA, aluOpB, brOpA, brOpB;

  operand_bypass_unit dut (
    .exSrcA(exSrcA), .exSrcB(exSrcB), .exRfA(exRfA), .exRfB(exRfB),
    .idSrcA(idSrcA), .idSrcB(idSrcB), .idRfA(idRfA), .idRfB(idRfB),
    .exMemWrEn(exMemWrEn), .exMemDest(exMemDest), .exMemAluRes(exMemAluRes),
    .memWbWrEn(memWbWrEn), .memWbDest(memWbDest), .memWbIsLoad(memWbIsLoad),
    .memWbAluRes(memWbAluRes), .memWbLoadData(memWbLoadData),
    .aluSelA(aluSelA), .aluSelB(aluSelB), .aluOpA(aluOpA), .aluOpB(aluOpB),
    .brSelA(brSelA), .brSelB(brSelB), .brOpA(brOpA), .brOpB(brOpB)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  function automatic string tagName(logic [3:0] t);
    case (t)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  // Expected ALU operand from the code meaning given in R1..R3 and R7.
  function automatic logic [31:0] expAlu(logic [1:0] sel, logic [31:0] rf, logic ld);
    if (sel == 2'b10)      return exMemAluRes;
    else if (sel == 2'b01) return ld ? memWbLoadData : memWbAluRes;
    else                   return rf;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic setData();
    exRfA = RF_A; exRfB = RF_B; idRfA = ID_A; idRfB = ID_B;
    exMemAluRes = EM_RES; memWbAluRes = WB_RES; memWbLoadData = LD_DAT;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    // Idle state: nothing in flight (R1).
    exSrcA = '0; exSrcB = '0; idSrcA = '0; idSrcB = '0;
    exMemWrEn = 1'b0; exMemDest = '0; memWbWrEn = 1'b0; memWbDest = '0; memWbIsLoad = 1'b0;
    setData();
    @(negedge clk); #1;
    chk("R1", "idle aluSelA", 32'(aluSelA), 32'd0);
    chk("R1", "idle aluSelB", 32'(aluSelB), 32'd0);
    chk("R1", "idle brSelA",  32'(brSelA),  32'd0);
    chk("R1", "idle aluOpA",  aluOpA, RF_A);
    chk("R1", "idle brOpB",   brOpB,  ID_B);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      exSrcA = VECS[i].exA; exSrcB = VECS[i].exB;
      idSrcA = VECS[i].idA; idSrcB = VECS[i].idB;
      exMemDest = VECS[i].emDest; exMemWrEn = VECS[i].emWe;
      memWbDest = VECS[i].wbDest; memWbWrEn = VECS[i].wbWe; memWbIsLoad = VECS[i].wbLd;
      #1;
      chk(tagName(VECS[i].tag), $sformatf("v%0d aluSelA", i), 32'(aluSelA), 32'(VECS[i].expA));
      chk(tagName(VECS[i].tag), $sformatf("v%0d aluSelB", i), 32'(aluSelB), 32'(VECS[i].expB));
      chk(tagName(VECS[i].tag), $sformatf("v%0d aluOpA", i), aluOpA, expAlu(VECS[i].expA, RF_A, VECS[i].wbLd));
      chk(tagName(VECS[i].tag), $sformatf("v%0d aluOpB", i), aluOpB, expAlu(VECS[i].expB, RF_B, VECS[i].wbLd));
      chk(tagName(VECS[i].tag), $sformatf("v%0d brSelA", i), 32'(brSelA), VECS[i].expBrA ? 32'd2 : 32'd0);
      chk(tagName(VECS[i].tag), $sformatf("v%0d brSelB", i), 32'(brSelB), VECS[i].expBrB ? 32'd2 : 32'd0);
      chk(tagName(VECS[i].tag), $sformatf("v%0d brOpA", i), brOpA, VECS[i].expBrA ? EM_RES : ID_A);
      chk(tagName(VECS[i].tag), $sformatf("v%0d brOpB", i), brOpB, VECS[i].expBrB ? EM_RES : ID_B);
      chk("R10", $sformatf("v%0d no code 11", i),
          32'((aluSelA == 2'b11) || (aluSelB == 2'b11) || (brSelA == 2'b11) || (brSelB == 2'b11)), 32'd0);
    end

    // R7: the same writeback match, load flag turned off -> ALU result.
    @(negedge clk);
    exSrcA = 5'd5; exSrcB = 5'd2; idSrcA = 5'd1; idSrcB = 5'd1;
    exMemDest = 5'd3; exMemWrEn = 1'b1; memWbDest = 5'd5; memWbWrEn = 1'b1; memWbIsLoad = 1'b1;
    #1;
    chk("R7", "load data forwarded", aluOpA, LD_DAT);
    memWbIsLoad = 1'b0;
    #1;
    chk("R7", "alu result forwarded", aluOpA, WB_RES);

    // R10: a forwarded operand follows a new producer value within the same cycle.
    @(negedge clk);
    exSrcA = 5'd20; exMemDest = 5'd20; exMemWrEn = 1'b1;
    #1;
    chk("R10", "first value", aluOpA, EM_RES);
    exMemAluRes = 32'h0BAD_F00D;
    #1;
    chk("R10", "updated value same cycle", aluOpA, 32'h0BAD_F00D);
    exMemAluRes = EM_RES;

    // R6: clearing only the execute/memory enable drops to the writeback match.
    @(negedge clk);
    exSrcA = 5'd17; exMemDest = 5'd17; exMemWrEn = 1'b0; memWbDest = 5'd17; memWbWrEn = 1'b1;
    memWbIsLoad = 1'b0;
    #1;
    chk("R6", "disabled younger producer ignored", 32'(aluSelA), 32'd1);
    chk("R6", "operand from writeback", aluOpA, WB_RES);

    // R8: a writeback-only match leaves the branch operand on the register file.
    @(negedge clk);
    idSrcA = 5'd17; exMemDest = 5'd4; exMemWrEn = 1'b1;
    #1;
    chk("R8", "branch ignores writeback match", 32'(brSelA), 32'd0);
    chk("R8", "branch operand from register file", brOpA, ID_A);

    @(negedge clk);
    finish();
  end

endmodule